// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox Port

This block is a single byte-wide mailbox channel that sits between an external host bus and an embedded slave processor, in the manner of a keyboard-controller host port. The host side sees two locations selected by a one-bit address line, and uses an active-low chip select, active-low read and write strobes and an 8-bit data bus. A host write places a byte in the input data register and records the address bit as a command/data marker. A host read at address 0 returns the output data register, and a host read at address 1 returns the status byte.

The slave side is a simple synchronous register port with four locations: input data, output data, status and one unused location. Two hardware flags carry the handshake between the two sides. The input-full flag is set when the host writes and cleared when the slave reads the input data. The output-full flag is set when the slave writes and cleared when a host read of the output data ends. The remaining five status bits belong to slave firmware, which can set them to give the host extra state. An optional interrupt request tells the slave that input is waiting.

The host strobes are asynchronous to the slave clock. Each strobe is brought into the slave clock domain through a synchroniser chain, and a single edge pulse is taken from it. This gives exactly one flag update per strobe, however long the host holds it.

Top module: `host_mailbox_port`

## Requirements
- R1: After a synchronous reset the status byte is 0x00, `slv_irq` is 0, and `host_rdata_oe` is 0.
- R2: `host_rdata_oe` is 1 only while `host_sel_n` and `host_rd_n` are both 0. While `host_rdata_oe` is 0, `host_rdata` is 0x00. While it is 1 with `host_addr`=0, `host_rdata` carries the output data register.
- R3: The status byte has this layout: bits 7..4 are user bits, bit 3 is command/data, bit 2 is a user bit, bit 1 is input-full and bit 0 is output-full. A host read with `host_addr`=1 returns the status byte.
- R4: A host write (`host_sel_n`=0, `host_wr_n`=0) at either address latches `host_wdata` into the input data register and sets input-full. It does this once per strobe, however many cycles the strobe is held. The slave reads the input data register at location 0.
- R5: On each host write, status bit 3 captures `host_addr`: 0 marks data and 1 marks a command. No other event changes bit 3.
- R6: A slave read of location 0 clears input-full. If a host write sets the flag in the same cycle, the set wins.
- R7: A slave write of location 1 loads the output data register and sets output-full. The end of a host read at address 0 clears output-full. A slave write in the same cycle wins over the clear. A host read at address 1 leaves output-full unchanged.
- R8: A slave write of location 2 updates status bits 7..4 and bit 2 from the written byte and leaves bits 3, 1 and 0 unchanged. The slave port returns read data one cycle after the read.
- R9: A slave write to location 0 or location 3 changes neither the input data register nor any flag.
- R10: With `IRQ_ENABLE`=1, `slv_irq` rises one cycle after input-full rises. It stays asserted while input-full is 1 and falls one cycle after input-full clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Host chip select, active low |
| host_addr | input | 1 | Host address bit (0 data, 1 status/command) |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, 0x00 when not driven |
| host_rdata_oe | output | 1 | Host data bus drive enable |
| slv_sel | input | 1 | Slave access strobe |
| slv_wr | input | 1 | Slave access is a write when 1 |
| slv_reg | input | 2 | Slave location: 0 input data, 1 output data, 2 status, 3 unused |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data, registered |
| slv_irq | output | 1 | Input-waiting interrupt request |

## Verification
The bench builds the block with `SYNC_STAGES`=3 and `IRQ_ENABLE`=1. This way the synchroniser depth differs from the default, and the interrupt path is present. Because the depth is known, the bench can place a slave access in exactly the cycle where a synchronised host edge takes effect, so both flag collisions (set against clear) can be reached. A host write strobe held for many cycles across a slave clear shows that each strobe is counted only once.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int BYTE_W = 8;

  // status byte bit positions (host software decodes these)
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_U2  = 2;
  localparam int ST_CD  = 3;
  localparam int ST_UHI = 4;
  localparam int UHI_W  = BYTE_W - ST_UHI;

  typedef enum logic [1:0] {
    LOC_IDR  = 2'd0,
    LOC_ODR  = 2'd1,
    LOC_STAT = 2'd2,
    LOC_NONE = 2'd3
  } slv_loc_e;
endpackage

// File: rtl/mbx_strobe_sync.sv
module mbx_strobe_sync #(
  parameter int STAGES   = 2,
  parameter bit TRAILING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic edge_pulse
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[TOP];
    end
  end

  generate
    if (TRAILING) begin : g_fall
      assign edge_pulse = last & ~chain[TOP];
    end else begin : g_rise
      assign edge_pulse = chain[TOP] & ~last;
    end
  endgenerate

  // one strobe yields one pulse, never two in a row
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_pulse,
  input  logic              host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_rd_done,
  input  logic              slv_sel,
  input  logic              slv_wr,
  input  logic [1:0]        slv_reg,
  input  logic [BYTE_W-1:0] slv_wdata,
  output logic [BYTE_W-1:0] slv_rdata,
  output logic [BYTE_W-1:0] odr_q,
  output logic [BYTE_W-1:0] status_q
);
  slv_loc_e          loc;
  logic              slv_rd_en, slv_wr_en;
  logic              idr_rd, odr_wr, stat_wr;
  logic [BYTE_W-1:0] idr_q;
  logic              ibf, obf, cd;
  logic [UHI_W-1:0]  user_hi;
  logic              user_b2;

  assign loc       = slv_loc_e'(slv_reg);
  assign slv_rd_en = slv_sel & ~slv_wr;
  assign slv_wr_en = slv_sel & slv_wr;
  assign idr_rd    = slv_rd_en & (loc == LOC_IDR);
  assign odr_wr    = slv_wr_en & (loc == LOC_ODR);
  assign stat_wr   = slv_wr_en & (loc == LOC_STAT);

  // data holding registers: no reset, plain load enables
  always_ff @(posedge clk) begin
    if (host_wr_pulse) idr_q <= host_wdata;
    if (odr_wr)        odr_q <= slv_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ibf <= 1'b0;
    end else if (host_wr_pulse) begin
      ibf <= 1'b1;
    end else if (idr_rd) begin
      ibf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obf <= 1'b0;
    end else if (odr_wr) begin
      obf <= 1'b1;
    end else if (host_rd_done) begin
      obf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cd <= 1'b0;
    end else if (host_wr_pulse) begin
      cd <= host_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      user_hi <= '0;
      user_b2 <= 1'b0;
    end else if (stat_wr) begin
      user_hi <= slv_wdata[BYTE_W-1:ST_UHI];
      user_b2 <= slv_wdata[ST_U2];
    end
  end

  assign status_q = {user_hi, cd, user_b2, ibf, obf};

  always_ff @(posedge clk) begin
    if (rst) begin
      slv_rdata <= '0;
    end else if (slv_rd_en) begin
      case (loc)
        LOC_IDR:  slv_rdata <= idr_q;
        LOC_ODR:  slv_rdata <= odr_q;
        LOC_STAT: slv_rdata <= status_q;
        default:  slv_rdata <= '0;
      endcase
    end
  end

  p_ibf_set_r4: assert property (@(posedge clk) disable iff (rst)
    host_wr_pulse |=> status_q[ST_IBF]);
  p_ibf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (idr_rd && !host_wr_pulse) |=> !status_q[ST_IBF]);
  p_obf_set_r7: assert property (@(posedge clk) disable iff (rst)
    odr_wr |=> status_q[ST_OBF]);
  p_obf_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (host_rd_done && !odr_wr) |=> !status_q[ST_OBF]);
  p_cd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !host_wr_pulse |=> $stable(status_q[ST_CD]));
  p_flags_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !host_wr_pulse && !host_rd_done) |=>
      $stable(status_q[ST_IBF]) && $stable(status_q[ST_OBF]));
  p_idr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (slv_wr_en && (loc == LOC_IDR) && !host_wr_pulse) |=> $stable(idr_q));
endmodule

// File: rtl/host_mailbox_port.sv
module host_mailbox_port
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit IRQ_ENABLE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel_n,
  input  logic              host_addr,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  input  logic              slv_sel,
  input  logic              slv_wr,
  input  logic [1:0]        slv_reg,
  input  logic [BYTE_W-1:0] slv_wdata,
  output logic [BYTE_W-1:0] slv_rdata,
  output logic              slv_irq
);
  logic              wr_active, rd_odr_active;
  logic              wr_pulse, rd_done;
  logic [BYTE_W-1:0] odr_q, status_q;

  assign wr_active     = ~host_sel_n & ~host_wr_n;
  assign rd_odr_active = ~host_sel_n & ~host_rd_n & ~host_addr;

  mbx_strobe_sync #(.STAGES(SYNC_STAGES), .TRAILING(1'b0)) u_wr_sync (
    .clk(clk), .rst(rst), .async_in(wr_active), .edge_pulse(wr_pulse)
  );

  mbx_strobe_sync #(.STAGES(SYNC_STAGES), .TRAILING(1'b1)) u_rd_sync (
    .clk(clk), .rst(rst), .async_in(rd_odr_active), .edge_pulse(rd_done)
  );

  mbx_regs u_regs (
    .clk(clk), .rst(rst),
    .host_wr_pulse(wr_pulse), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd_done(rd_done),
    .slv_sel(slv_sel), .slv_wr(slv_wr), .slv_reg(slv_reg), .slv_wdata(slv_wdata),
    .slv_rdata(slv_rdata), .odr_q(odr_q), .status_q(status_q)
  );

  // host read path is asynchronous to the slave clock: a combinational mux
  always_comb begin
    host_rdata_oe = ~host_sel_n & ~host_rd_n;
    host_rdata    = '0;
    if (host_rdata_oe) host_rdata = host_addr ? status_q : odr_q;
  end

  generate
    if (IRQ_ENABLE) begin : g_irq
      always_ff @(posedge clk) begin
        if (rst) slv_irq <= 1'b0;
        else     slv_irq <= status_q[ST_IBF];
      end
      p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[ST_IBF]) |=> slv_irq);
      p_irq_fall_r10: assert property (@(posedge clk) disable iff (rst)
        !status_q[ST_IBF] |=> !slv_irq);
    end else begin : g_no_irq
      assign slv_irq = 1'b0;
    end
  endgenerate

  p_bus_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !host_rdata_oe |-> (host_rdata == '0));
endmodule

// File: tb/host_mailbox_port_bench.sv
module host_mailbox_port_bench;
  localparam int SYNC = 3;

  logic       clk = 1'b0;
  logic       rst;
  logic       host_sel_n, host_addr, host_rd_n, host_wr_n;
  logic [7:0] host_wdata, host_rdata;
  logic       host_rdata_oe;
  logic       slv_sel, slv_wr;
  logic [1:0] slv_reg;
  logic [7:0] slv_wdata, slv_rdata;
  logic       slv_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  host_mailbox_port #(.SYNC_STAGES(SYNC), .IRQ_ENABLE(1'b1)) u_host_mailbox_port (
    .clk(clk), .rst(rst),
    .host_sel_n(host_sel_n), .host_addr(host_addr), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdata_oe(host_rdata_oe),
    .slv_sel(slv_sel), .slv_wr(slv_wr), .slv_reg(slv_reg), .slv_wdata(slv_wdata),
    .slv_rdata(slv_rdata), .slv_irq(slv_irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  task automatic slave_write(input logic [1:0] loc, input logic [7:0] d);
    @(negedge clk);
    slv_sel = 1'b1; slv_wr = 1'b1; slv_reg = loc; slv_wdata = d;
    @(negedge clk);
    slv_sel = 1'b0; slv_wr = 1'b0;
  endtask

  task automatic slave_read(input logic [1:0] loc, output logic [7:0] d);
    @(negedge clk);
    slv_sel = 1'b1; slv_wr = 1'b0; slv_reg = loc;
    @(negedge clk);
    slv_sel = 1'b0;
    d = slv_rdata;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    host_sel_n = 1'b0; host_addr = a; host_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    d = host_rdata; oe = host_rdata_oe;
    host_rd_n = 1'b1; host_sel_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_sel_n = 1'b0; host_addr = a; host_wdata = d; host_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    host_wr_n = 1'b1; host_sel_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 irq", {7'd0, slv_irq}, 8'h00);
    check("R1 oe", {7'd0, host_rdata_oe}, 8'h00);
    slave_read(2'd2, v);
    check("R1 status", v, 8'h00);
  endtask

  task automatic t_idle_bus;
    @(negedge clk);
    host_sel_n = 1'b1; host_rd_n = 1'b0; host_addr = 1'b0;
    @(negedge clk);
    check("R2 oe sel high", {7'd0, host_rdata_oe}, 8'h00);
    check("R2 bus zero", host_rdata, 8'h00);
    host_rd_n = 1'b1;
  endtask

  task automatic t_odr;
    logic [7:0] v; logic oe;
    slave_write(2'd1, 8'hA5);
    slave_read(2'd2, v);
    check("R7 obf set", v & 8'h01, 8'h01);
    host_read(1'b1, v, oe);
    check("R3 host status", v, 8'h01);
    slave_read(2'd2, v);
    check("R7 obf kept on status read", v & 8'h01, 8'h01);
    host_read(1'b0, v, oe);
    check("R2 host odr", v, 8'hA5);
    check("R2 oe", {7'd0, oe}, 8'h01);
    slave_read(2'd2, v);
    check("R7 obf cleared", v & 8'h01, 8'h00);
    slave_read(2'd1, v);
    check("R7 slave odr", v, 8'hA5);
  endtask

  task automatic t_write_irq;
    logic [7:0] v;
    host_write(1'b0, 8'h3C);
    check("R10 irq high", {7'd0, slv_irq}, 8'h01);
    slave_read(2'd2, v);
    check("R4 ibf set", v & 8'h02, 8'h02);
    slave_read(2'd0, v);
    check("R4 idr data", v, 8'h3C);
    repeat (2) @(negedge clk);
    check("R10 irq low", {7'd0, slv_irq}, 8'h00);
    slave_read(2'd2, v);
    check("R6 ibf cleared", v & 8'h02, 8'h00);
  endtask

  task automatic t_long_strobe;
    logic [7:0] v;
    @(negedge clk);
    host_sel_n = 1'b0; host_addr = 1'b0; host_wdata = 8'h5A; host_wr_n = 1'b0;
    repeat (SYNC + 4) @(negedge clk);
    slave_read(2'd0, v);
    check("R4 long strobe data", v, 8'h5A);
    repeat (20) @(negedge clk);
    slave_read(2'd2, v);
    check("R4 one update per strobe", v & 8'h02, 8'h00);
    host_wr_n = 1'b1; host_sel_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    slave_read(2'd2, v);
    check("R4 no set on release", v & 8'h02, 8'h00);
  endtask

  task automatic t_cmd_data;
    logic [7:0] v; logic oe;
    host_write(1'b1, 8'h81);
    host_read(1'b1, v, oe);
    check("R5 command flag", v & 8'h0A, 8'h0A);
    slave_read(2'd0, v);
    check("R5 command byte", v, 8'h81);
    host_write(1'b0, 8'h12);
    slave_read(2'd2, v);
    check("R5 data flag", v & 8'h0A, 8'h02);
    slave_read(2'd0, v);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    slave_write(2'd0, 8'h55);
    slave_write(2'd3, 8'hFF);
    slave_read(2'd0, v);
    check("R9 idr unchanged", v, 8'h12);
    slave_read(2'd2, v);
    check("R9 flags unchanged", v, 8'h00);
  endtask

  task automatic t_user_bits;
    logic [7:0] v; logic oe;
    slave_write(2'd2, 8'hFF);
    slave_read(2'd2, v);
    check("R8 user bits set", v, 8'hF4);
    host_read(1'b1, v, oe);
    check("R3 host sees user bits", v, 8'hF4);
    slave_write(2'd2, 8'h0B);
    slave_read(2'd2, v);
    check("R8 hw bits protected", v, 8'h00);
  endtask

  task automatic t_ibf_collision;
    logic [7:0] v;
    @(negedge clk);
    host_sel_n = 1'b0; host_addr = 1'b0; host_wdata = 8'h77; host_wr_n = 1'b0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    slv_sel = 1'b1; slv_wr = 1'b0; slv_reg = 2'd0;
    @(negedge clk);
    slv_sel = 1'b0;
    host_wr_n = 1'b1; host_sel_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    slave_read(2'd2, v);
    check("R6 set wins over clear", v & 8'h02, 8'h02);
    slave_read(2'd0, v);
    check("R6 collided data", v, 8'h77);
  endtask

  task automatic t_obf_collision;
    logic [7:0] v; logic oe;
    slave_write(2'd1, 8'h11);
    @(negedge clk);
    host_sel_n = 1'b0; host_addr = 1'b0; host_rd_n = 1'b0;
    repeat (SYNC + 3) @(negedge clk);
    host_rd_n = 1'b1; host_sel_n = 1'b1;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    slv_sel = 1'b1; slv_wr = 1'b1; slv_reg = 2'd1; slv_wdata = 8'h22;
    @(negedge clk);
    slv_sel = 1'b0; slv_wr = 1'b0;
    repeat (3) @(negedge clk);
    slave_read(2'd2, v);
    check("R7 write wins over clear", v & 8'h01, 8'h01);
    host_read(1'b0, v, oe);
    check("R7 new odr", v, 8'h22);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    host_sel_n = 1'b1; host_addr = 1'b0; host_rd_n = 1'b1; host_wr_n = 1'b1;
    host_wdata = 8'h00;
    slv_sel = 1'b0; slv_wr = 1'b0; slv_reg = 2'd0; slv_wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_bus();
    t_odr();
    t_write_irq();
    t_long_strobe();
    t_cmd_data();
    t_ignored();
    t_user_bits();
    t_ibf_collision();
    t_obf_collision();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule